// File: doc/BRIEF.md
# Generalized Bit-Reverse Permutation Unit

This execution-unit datapath rearranges the bits of a source operand under an XOR-style control value. Output bit i is taken from operand bit (control XOR i), with the index reduced modulo the active width. A zero control gives the identity permutation. A control of all ones gives a full mirror. Intermediate values swap bit pairs, nibbles, bytes, halves and so on.

The control comes from a second register operand or from an immediate field, chosen by a select input. In word mode, only the low half of the operand takes part. In that mode the upper half of the result is forced to zero.

When the record flag is set, the unit also produces a 4-bit condition field and marks it valid. The field holds three flags from a signed comparison of the result with zero, plus a summary-overflow bit taken from an input. The permutation is a chain of butterfly stages, followed by one output register with a valid flag.

Top module: `grev_unit`

## Requirements
- R1: In full-width mode (word_mode=0), result bit i equals operand bit ((c XOR i) mod XLEN) for every i, where c is the selected control.
- R2: Only the low log2(XLEN) bits of ctl_reg affect the result. Higher bits of ctl_reg are ignored.
- R3: In word mode (word_mode=1), result bit i equals operand bit ((c XOR i) mod XLEN/2) for i below XLEN/2, and result bits XLEN/2 and above are zero.
- R4: In word mode, operand bits XLEN/2 and above have no effect on the result.
- R5: use_imm=1 takes the control from ctl_imm (log2(XLEN) bits). use_imm=0 takes it from ctl_reg. The permutation rule is the same in both cases.
- R6: A control of 0 returns the operand unchanged in the active width. A control of all ones in the active index bits mirrors the active width, so bit i takes bit W-1-i.
- R7: With record=1, cr_valid is 1 and cr = {LT, GT, EQ, SO} in bits 3 down to 0. LT, GT and EQ come from a signed comparison of the full XLEN-bit result with zero, and SO equals so_in.
- R8: With record=0, cr_valid is 0 and cr is 4'b0000.
- R9: out_valid and the outputs update one clock after in_valid is sampled high. The outputs hold while in_valid is low. A synchronous active-high rst clears out_valid, result, cr and cr_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation valid |
| operand | input | XLEN | Source value to permute |
| ctl_reg | input | XLEN | Control from register operand |
| ctl_imm | input | log2(XLEN) | Control from immediate field |
| use_imm | input | 1 | 1 selects ctl_imm, 0 selects ctl_reg |
| word_mode | input | 1 | Permute low half only, zero upper half |
| record | input | 1 | Produce the condition field |
| so_in | input | 1 | Summary-overflow bit copied into cr |
| out_valid | output | 1 | Result valid |
| result | output | XLEN | Permuted value |
| cr | output | 4 | {LT, GT, EQ, SO} |
| cr_valid | output | 1 | Condition field valid |

## Verification
The hardest case to reach is one where the stage gating and the word-mode masking interact. That happens when a control has its top index bit set while word mode is on. The top stage must then stay idle, so upper operand bits cannot leak into the low half. The stimulus drives word-mode operations with the top control bit set and distinct upper operand halves, and checks that the results match. It also sends full-width controls with junk in the high ctl_reg bits, and register controls that disagree with the immediate. Together these show that only the selected low index bits steer the butterfly.

// File: rtl/grev_unit.sv
module grev_unit #(
  parameter int XLEN = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int LG = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] operand,
  input  logic [XLEN-1:0] ctl_reg,
  input  logic [LG-1:0]   ctl_imm,
  input  logic            use_imm,
  input  logic            word_mode,
  input  logic            record,
  input  logic            so_in,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic [3:0]      cr,
  output logic            cr_valid
);
  localparam int H = XLEN / 2;

  function automatic logic [XLEN-1:0] swap_blocks(input logic [XLEN-1:0] x, input int k);
    logic [XLEN-1:0] y;
    for (int i = 0; i < XLEN; i++) y[i] = x[i ^ (1 << k)];
    return y;
  endfunction

  logic [LG-1:0]   ctl;
  logic [XLEN-1:0] stg [0:LG];
  logic [XLEN-1:0] res_c;
  logic [3:0]      cr_c;
  logic            neg, zero;

  assign ctl    = use_imm ? ctl_imm : ctl_reg[LG-1:0];
  assign stg[0] = operand;

  for (genvar k = 0; k < LG; k++) begin : g_stage
    logic act;
    assign act        = ctl[k] & (~word_mode | (k < LG - 1));
    assign stg[k + 1] = act ? swap_blocks(stg[k], k) : stg[k];
  end

  assign res_c = word_mode ? {{(XLEN - H){1'b0}}, stg[LG][H-1:0]} : stg[LG];
  assign neg   = res_c[XLEN-1];
  assign zero  = (res_c == '0);
  assign cr_c  = record ? {neg, ~neg & ~zero, zero, so_in} : 4'b0000;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        result    <= '0;
        cr        <= 4'b0000;
        cr_valid  <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          result   <= res_c;
          cr       <= cr_c;
          cr_valid <= record;
        end
      end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
      out_valid == $past(in_valid)) else $error("valid latency"); // R9
    AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      in_valid && word_mode |=> result[XLEN-1:H] == '0) else $error("upper half"); // R3
    AST_CR_GATED: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> cr_valid == $past(record)) else $error("cr valid"); // R8
    AST_CR_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
      cr_valid |-> $countones(cr[3:1]) == 1) else $error("cr flags"); // R7
    AST_CR_EQ_ZERO: assert property (@(posedge clk) disable iff (rst)
      cr_valid |-> cr[1] == (result == '0)) else $error("eq flag"); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result)) else $error("hold"); // R9
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = res_c;
    assign cr        = cr_c;
    assign cr_valid  = record;
  end
endmodule

// File: tb/tb_grev_unit.sv
module tb_grev_unit;
  localparam int XLEN = 64;
  localparam int LG = 6;
  localparam int H = XLEN / 2;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [XLEN-1:0] operand = '0, ctl_reg = '0;
  logic [LG-1:0] ctl_imm = '0;
  logic use_imm = 0, word_mode = 0, record = 0, so_in = 0;
  logic out_valid, cr_valid;
  logic [XLEN-1:0] result;
  logic [3:0] cr;

  grev_unit #(.XLEN(XLEN)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [XLEN+4:0] exp_q[$];
  string tag_q[$];
  logic [XLEN-1:0] last_res;

  function automatic logic [XLEN-1:0] model(input logic [XLEN-1:0] op, input logic [XLEN-1:0] c, input bit w);
    logic [XLEN-1:0] r = '0;
    int wid = w ? H : XLEN;
    for (int i = 0; i < wid; i++) r[i] = op[int'((c ^ XLEN'(i)) % XLEN'(wid))];
    return r;
  endfunction

  function automatic logic [XLEN-1:0] mirror(input logic [XLEN-1:0] op, input bit w);
    logic [XLEN-1:0] r = '0;
    int wid = w ? H : XLEN;
    for (int i = 0; i < wid; i++) r[i] = op[wid - 1 - i];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [XLEN-1:0] op, input logic [XLEN-1:0] creg, input logic [LG-1:0] cimm,
                      input bit ui, input bit w, input bit rec, input bit so,
                      input bit use_want, input logic [XLEN-1:0] want, input string tag);
    logic [XLEN-1:0] c, r;
    logic [3:0] e;
    @(negedge clk);
    operand = op; ctl_reg = creg; ctl_imm = cimm; use_imm = ui;
    word_mode = w; record = rec; so_in = so; in_valid = 1;
    c = ui ? XLEN'(cimm) : creg;
    r = use_want ? want : model(op, c, w);
    if (rec) e = {r[XLEN-1], !r[XLEN-1] && r != 0, r == 0, so};
    else e = 4'b0;
    exp_q.push_back({r, e, rec});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      logic [XLEN+4:0] it;
      string t;
      if (exp_q.size() == 0) check(0, "R9 unexpected out_valid", '0, '0);
      else begin
        it = exp_q.pop_front(); t = tag_q.pop_front();
        check(result === it[XLEN+4:5], t, result, it[XLEN+4:5]);
        check(cr === it[4:1], {t, " R7/R8 cr"}, XLEN'(cr), XLEN'(it[4:1]));
        check(cr_valid === it[0], {t, " R7/R8 cr_valid"}, XLEN'(cr_valid), XLEN'(it[0]));
        last_res = it[XLEN+4:5];
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] a, b, cr1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid === 0 && result === '0 && cr === 0 && cr_valid === 0, "R9 reset state",
          result, '0);
    rst = 0;
    a = 64'h0123_4567_89AB_CDEF;
    // R6 identity and mirror
    send(a, '0, '0, 0, 0, 0, 0, 1, a, "R6 identity");
    send(a, 64'd63, '0, 0, 0, 0, 0, 1, mirror(a, 0), "R6 full mirror");
    send(a, 64'd31, '0, 0, 1, 0, 0, 1, mirror(a, 1), "R6 word mirror");
    // R1 patterns
    for (int k = 0; k < 20; k++) begin
      b = {$urandom, $urandom};
      send(b, XLEN'(k * 7 % 64), '0, 0, 0, 0, 0, 0, '0, "R1 full width");
    end
    // R2 junk high control bits
    send(a, 64'hFFFF_FFFF_FFFF_FF05, '0, 0, 0, 0, 0, 1, model(a, 64'd5, 0), "R2 high ctl ignored");
    send(a, 64'hA5A5_0000_0000_0040, '0, 0, 0, 0, 0, 1, a, "R2 bit6 ignored");
    // R3 word mode
    for (int k = 0; k < 10; k++) begin
      b = {$urandom, $urandom};
      send(b, XLEN'(k * 13 % 64), '0, 0, 1, 0, 0, 0, '0, "R3 word mode");
    end
    // R4 upper half of operand ignored, top control bit set
    cr1 = model({32'h0, 32'hDEAD_BEEF}, 64'd45, 1);
    send({32'hFFFF_FFFF, 32'hDEAD_BEEF}, 64'd45, '0, 0, 1, 0, 0, 1, cr1, "R4 upper ones");
    send({32'h1234_5678, 32'hDEAD_BEEF}, 64'd45, '0, 0, 1, 0, 0, 1, cr1, "R4 upper pattern");
    // R5 immediate vs register
    send(a, 64'd3, 6'd40, 1, 0, 0, 0, 1, model(a, 64'd40, 0), "R5 imm selected");
    send(a, 64'd40, 6'd3, 0, 0, 0, 0, 1, model(a, 64'd40, 0), "R5 reg selected");
    send(a, 64'd0, 6'd21, 1, 1, 0, 0, 1, model(a, 64'd21, 1), "R5 imm word");
    // R7 record with negative, positive, zero; R8 no record
    send(64'h8000_0000_0000_0000, '0, '0, 0, 0, 1, 1, 0, '0, "R7 negative so=1");
    send(64'h0000_0000_0000_0001, '0, '0, 0, 0, 1, 0, 0, '0, "R7 positive");
    send('0, 64'd9, '0, 0, 0, 1, 1, 0, '0, "R7 zero");
    send(64'h8000_0000_0000_0000, 64'd63, '0, 0, 0, 1, 0, 0, '0, "R7 moved positive");
    send(64'h0000_0001_0000_0000, '0, '0, 0, 1, 1, 0, 0, '0, "R7 word zero");
    send(64'h8000_0000_0000_0000, '0, '0, 0, 0, 0, 1, 0, '0, "R8 no record");
    @(negedge clk);
    in_valid = 0;
    operand = '1; ctl_reg = 64'd7;
    repeat (4) @(negedge clk);
    check(out_valid === 0, "R9 idle valid", XLEN'(out_valid), '0);
    check(result === last_res, "R9 hold", result, last_res);
    check(exp_q.size() == 0, "R9 all results", XLEN'(exp_q.size()), '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule